// File: doc/BRIEF.md
# Transceiver Reset Sequencer

This block sits between the reset sources of an Ethernet-style transceiver and the rest of its logic. It merges three reset requests into one reset condition. The requests are a power-on reset, a hardware reset pin and a self-clearing software reset bit. While the condition holds, the block keeps the transceiver in a safe state:
- the MAC-side receive data is gated to zero toward the core;
- the MAC-side output pins are driven low rather than floated, so a partner that is already powered can be connected safely;
- the line transmit driver is tri-stated;
- the internal state machines are held in reset;
- the analog section is kept in power-down;
- the latching status bits are held at their defaults.

When the condition ends, a step counter plays out a fixed exit order. Each step is `STEP_GAP` clocks after the previous one. The order is:
1. leave power-down;
2. capture the strap address into the extended control register;
3. release the internal state machines;
4. load the configuration register;
5. enable the transmit driver;
6. pulse the transmit and receive PLL resynchronisation requests;
7. release the MAC-side pins.

The hardware and power-on sources assert asynchronously and are released through a two-flop synchroniser. A mode pin decides whether the configuration register loads a fixed default or the values presented on the strap pins. A software reset, or a hardware reset that arrives during the exit sequence, restarts the sequence from the reset state.

Top module: `xcvr_rst_seq`

## Requirements
- R1: When `por_n` or `hw_rst_n` is low, the reset state takes effect at once, with no clock edge. When `sw_rst_set` is seen at a clock edge, the reset state takes effect from that edge. In the reset state: `pwr_down`=1, `sm_rst`=1, `tx_drv_en`=0, `latch_clr`=1, `core_in`=0, `mac_pin_out`=0 and `seq_done`=0.
- R2: Removal of the hardware and power-on sources passes through two synchroniser flops. Exit step 1 takes effect at the third rising edge after removal.
- R3: The exit steps take effect in this order, `STEP_GAP` cycles apart: step 1 `pwr_down` falls; step 2 address capture; step 3 `sm_rst` falls; step 4 configuration load; step 5 `tx_drv_en` rises; step 6 PLL pulses; step 7 MAC release.
- R4: `ext_ctl` bits 10:6 hold `strap_addr` as sampled at step 2, and all other bits of `ext_ctl` read 0. Strap changes made outside step 2 have no effect on `ext_ctl`.
- R5: At step 4, `cfg_reg` loads `strap_cfg` when `hwsw_mode`=1, and loads the parameter `CFG_DEF` (default 8'h35) when `hwsw_mode`=0.
- R6: With default parameters, the MAC-side pins are released at the 9th rising edge after the reset sources are removed. That is at most 16 cycles (640 ns at 25 MHz).
- R7: `sw_rst_bit` reads 1 from the edge that sees `sw_rst_set` until the edge at which `seq_done` rises. It reads 0 at that edge.
- R8: A `sw_rst_set` or a hardware reset that arrives during the exit sequence returns the block to the reset state. The whole exit sequence then runs again from step 1.
- R9: `tx_pll_resync` and `rx_pll_resync` are high together for exactly one cycle per exit sequence.
- R10: `seq_done` rises one cycle after the MAC release and stays high until the next reset.
- R11: Once released, `core_in` equals `mac_pin_in` and `mac_pin_out` equals `core_out`.
- R12: `latch_clr` is high only while the block is in the reset state. It is low from exit step 1 onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| hw_rst_n | input | 1 | Hardware reset pin, active low, asynchronous |
| sw_rst_set | input | 1 | Management write of the software reset bit (one-cycle strobe) |
| hwsw_mode | input | 1 | 1: configuration comes from the strap pins; 0: configuration comes from the default |
| strap_addr | input | ADDR_W (5) | Strap-pin management port address |
| strap_cfg | input | CFG_W (8) | Strap-pin configuration values |
| mac_pin_in | input | MAC_W (4) | Data arriving on the MAC-side pins |
| core_out | input | MAC_W (4) | Data from the core toward the MAC-side pins |
| core_in | output | MAC_W (4) | Gated MAC-side input data toward the core |
| mac_pin_out | output | MAC_W (4) | MAC-side output pins, forced low until released |
| tx_drv_en | output | 1 | Line transmit driver enable (0 = tri-state) |
| pwr_down | output | 1 | Power-down request to the analog section |
| sm_rst | output | 1 | Reset for the internal state machines |
| latch_clr | output | 1 | Holds the latching status bits at their defaults |
| tx_pll_resync | output | 1 | One-cycle transmit PLL resynchronisation request |
| rx_pll_resync | output | 1 | One-cycle receive PLL resynchronisation request |
| ext_ctl | output | 16 | Extended control register; address in bits 10:6 |
| cfg_reg | output | CFG_W (8) | Loaded configuration register |
| sw_rst_bit | output | 1 | Software reset bit as read back (self-clearing) |
| seq_done | output | 1 | Exit sequence complete |

## Verification
The exit sequence is tried with three kinds of input pattern, and each one distinguishes a different fault.
- **Start of the sequence.** A power-on release and a software reset start the sequence two cycles apart. Walking both cycle by cycle separates a missing or extra synchroniser stage from a fault in the step order.
- **Mode pin and straps.** Runs with `hwsw_mode` at each value, with straps that differ from `CFG_DEF`, show whether the load takes the wrong source. Changing the straps after release shows whether a capture happens at the wrong time.
- **Restarts.** Requests arrive in the middle of the exit sequence, as a software strobe and as an asynchronous pin drop. These check that the order is restarted rather than resumed, and that the PLL pulse and the self-clearing bit follow the restarted sequence.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  typedef enum logic [1:0] {
    PH_RST  = 2'd0,
    PH_EXIT = 2'd1,
    PH_RUN  = 2'd2
  } rsq_phase_e;

  // exit step numbers; their order is the required behaviour
  localparam int unsigned STEP_PWR  = 1;
  localparam int unsigned STEP_ADDR = 2;
  localparam int unsigned STEP_SM   = 3;
  localparam int unsigned STEP_LOAD = 4;
  localparam int unsigned STEP_TX   = 5;
  localparam int unsigned STEP_PLL  = 6;
  localparam int unsigned STEP_REL  = 7;

  // counter value at which a step fires
  function automatic int unsigned step_at(int unsigned step, int unsigned gap);
    return step * gap;
  endfunction

  // true once a step has been reached in the exit sequence, or in run
  function automatic logic reached(rsq_phase_e ph, logic [31:0] cnt, logic [31:0] at);
    return (ph == PH_RUN) || ((ph == PH_EXIT) && (cnt >= at));
  endfunction

  // rising edges from source removal to MAC release
  function automatic int unsigned release_latency(int unsigned sync_stages, int unsigned gap);
    return sync_stages + step_at(STEP_REL, gap);
  endfunction

endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst,
  output logic hold
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or posedge arst) begin
        if (arst) sr_q <= 1'b1;
        else      sr_q <= 1'b0;
      end
    end else begin : g_chain
      always_ff @(posedge clk or posedge arst) begin
        if (arst) sr_q <= '1;
        else      sr_q <= {sr_q[STAGES-2:0], 1'b0};
      end
    end
  endgenerate

  assign hold = sr_q[STAGES-1];
endmodule

// File: rtl/rsq_stepper.sv
module rsq_stepper
  import rsq_pkg::*;
#(
  parameter int unsigned GAP = 1,
  parameter int unsigned CW  = 3
) (
  input  logic          clk,
  input  logic          arst,
  input  logic          hold,
  input  logic          restart,
  output rsq_phase_e    ph,
  output logic [CW-1:0] cnt,
  output logic          last_ev
);
  localparam logic [CW-1:0] LAST = CW'(step_at(STEP_REL, GAP));

  rsq_phase_e    ph_q;
  logic [CW-1:0] cnt_q;

  assign last_ev = (ph_q == PH_EXIT) && (cnt_q == LAST) && !hold && !restart;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      ph_q  <= PH_RST;
      cnt_q <= '0;
    end else if (hold || restart) begin
      ph_q  <= PH_RST;
      cnt_q <= '0;
    end else begin
      unique case (ph_q)
        PH_RST: begin
          ph_q  <= PH_EXIT;
          cnt_q <= CW'(1);
        end
        PH_EXIT: begin
          if (cnt_q == LAST) ph_q <= PH_RUN;
          else               cnt_q <= cnt_q + CW'(1);
        end
        default: ph_q <= PH_RUN;
      endcase
    end
  end

  assign ph  = ph_q;
  assign cnt = cnt_q;
endmodule

// File: rtl/rsq_regs.sv
module rsq_regs #(
  parameter int unsigned         ADDR_W  = 5,
  parameter int unsigned         CFG_W   = 8,
  parameter logic [CFG_W-1:0]    CFG_DEF = 8'h35
) (
  input  logic              clk,
  input  logic              arst,
  input  logic              addr_ev,
  input  logic              load_ev,
  input  logic              sw_set,
  input  logic              done_ev,
  input  logic              hwsw_mode,
  input  logic [ADDR_W-1:0] strap_addr,
  input  logic [CFG_W-1:0]  strap_cfg,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CFG_W-1:0]  cfg_q,
  output logic              sw_bit
);
  always_ff @(posedge clk or posedge arst) begin
    if (arst)         addr_q <= '0;
    else if (addr_ev) addr_q <= strap_addr;
  end

  always_ff @(posedge clk or posedge arst) begin
    if (arst)         cfg_q <= CFG_DEF;
    else if (load_ev) cfg_q <= hwsw_mode ? strap_cfg : CFG_DEF;
  end

  always_ff @(posedge clk or posedge arst) begin
    if (arst)         sw_bit <= 1'b0;
    else if (sw_set)  sw_bit <= 1'b1;
    else if (done_ev) sw_bit <= 1'b0;
  end
endmodule

// File: rtl/xcvr_rst_seq.sv
module xcvr_rst_seq
  import rsq_pkg::*;
#(
  parameter int unsigned      SYNC_STAGES = 2,
  parameter int unsigned      STEP_GAP    = 1,
  parameter int unsigned      ADDR_W      = 5,
  parameter int unsigned      ADDR_LSB    = 6,
  parameter int unsigned      CFG_W       = 8,
  parameter logic [CFG_W-1:0] CFG_DEF     = 8'h35,
  parameter int unsigned      MAC_W       = 4
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              hw_rst_n,
  input  logic              sw_rst_set,
  input  logic              hwsw_mode,
  input  logic [ADDR_W-1:0] strap_addr,
  input  logic [CFG_W-1:0]  strap_cfg,
  input  logic [MAC_W-1:0]  mac_pin_in,
  input  logic [MAC_W-1:0]  core_out,
  output logic [MAC_W-1:0]  core_in,
  output logic [MAC_W-1:0]  mac_pin_out,
  output logic              tx_drv_en,
  output logic              pwr_down,
  output logic              sm_rst,
  output logic              latch_clr,
  output logic              tx_pll_resync,
  output logic              rx_pll_resync,
  output logic [15:0]       ext_ctl,
  output logic [CFG_W-1:0]  cfg_reg,
  output logic              sw_rst_bit,
  output logic              seq_done
);
  localparam int unsigned LAST_AT = step_at(STEP_REL, STEP_GAP);
  localparam int unsigned CW      = $clog2(LAST_AT + 1);
  localparam logic [31:0] AT_PWR  = 32'(step_at(STEP_PWR,  STEP_GAP));
  localparam logic [31:0] AT_ADDR = 32'(step_at(STEP_ADDR, STEP_GAP));
  localparam logic [31:0] AT_SM   = 32'(step_at(STEP_SM,   STEP_GAP));
  localparam logic [31:0] AT_LOAD = 32'(step_at(STEP_LOAD, STEP_GAP));
  localparam logic [31:0] AT_TX   = 32'(step_at(STEP_TX,   STEP_GAP));
  localparam logic [31:0] AT_PLL  = 32'(step_at(STEP_PLL,  STEP_GAP));
  localparam logic [31:0] AT_REL  = 32'(step_at(STEP_REL,  STEP_GAP));

  // named internal events, also watched by the checker
  logic          raw_rst;
  logic          hold;
  rsq_phase_e    ph;
  logic [CW-1:0] cnt;
  logic [31:0]   cnt32;
  logic          in_rst;
  logic          in_exit;
  logic          rel;
  logic          addr_ev;
  logic          load_ev;
  logic          pll_ev;
  logic          done_ev;
  logic [ADDR_W-1:0] addr_q;

  assign raw_rst = !por_n || !hw_rst_n;

  rsq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .arst (raw_rst),
    .hold (hold)
  );

  rsq_stepper #(.GAP(STEP_GAP), .CW(CW)) u_step (
    .clk     (clk),
    .arst    (raw_rst),
    .hold    (hold),
    .restart (sw_rst_set),
    .ph      (ph),
    .cnt     (cnt),
    .last_ev (done_ev)
  );

  assign cnt32   = 32'(cnt);
  assign in_rst  = (ph == PH_RST);
  assign in_exit = (ph == PH_EXIT);
  assign addr_ev = in_exit && (cnt32 == AT_ADDR);
  assign load_ev = in_exit && (cnt32 == AT_LOAD);
  assign pll_ev  = in_exit && (cnt32 == AT_PLL);
  assign rel     = reached(ph, cnt32, AT_REL);

  rsq_regs #(.ADDR_W(ADDR_W), .CFG_W(CFG_W), .CFG_DEF(CFG_DEF)) u_regs (
    .clk        (clk),
    .arst       (raw_rst),
    .addr_ev    (addr_ev),
    .load_ev    (load_ev),
    .sw_set     (sw_rst_set),
    .done_ev    (done_ev),
    .hwsw_mode  (hwsw_mode),
    .strap_addr (strap_addr),
    .strap_cfg  (strap_cfg),
    .addr_q     (addr_q),
    .cfg_q      (cfg_reg),
    .sw_bit     (sw_rst_bit)
  );

  assign pwr_down      = !reached(ph, cnt32, AT_PWR);
  assign sm_rst        = !reached(ph, cnt32, AT_SM);
  assign tx_drv_en     = reached(ph, cnt32, AT_TX);
  assign latch_clr     = in_rst;
  assign tx_pll_resync = pll_ev;
  assign rx_pll_resync = pll_ev;
  assign seq_done      = (ph == PH_RUN);
  assign core_in       = rel ? mac_pin_in : '0;
  assign mac_pin_out   = rel ? core_out : '0;

  always_comb begin
    ext_ctl = '0;
    ext_ctl[ADDR_LSB +: ADDR_W] = addr_q;
  end
endmodule

// File: rtl/rsq_chk.sv
module rsq_chk #(
  parameter int unsigned MAX_CYC = 16
) (
  input logic clk,
  input logic raw_rst,
  input logic hold,
  input logic in_rst,
  input logic rel,
  input logic pwr_down,
  input logic sm_rst,
  input logic tx_drv_en,
  input logic latch_clr,
  input logic tx_pll,
  input logic rx_pll,
  input logic seq_done,
  input logic sw_bit
);
  logic [$clog2(MAX_CYC + 2)-1:0] lat_q;

  always_ff @(posedge clk or posedge raw_rst) begin
    if (raw_rst)                    lat_q <= '0;
    else if (hold || in_rst)        lat_q <= '0;
    else if (!rel && lat_q <= MAX_CYC) lat_q <= lat_q + 1'b1;
  end

  a_r1_reset_blocks: assert property (@(posedge clk) disable iff (raw_rst)
    in_rst |-> (pwr_down && sm_rst && !tx_drv_en && !rel && !seq_done));

  a_r3_tx_after_wake: assert property (@(posedge clk) disable iff (raw_rst)
    tx_drv_en |-> (!pwr_down && !sm_rst));

  a_r3_release_after_tx: assert property (@(posedge clk) disable iff (raw_rst)
    rel |-> tx_drv_en);

  a_r6_release_bound: assert property (@(posedge clk) disable iff (raw_rst)
    lat_q <= MAX_CYC);

  a_r9_pll_one_cycle: assert property (@(posedge clk) disable iff (raw_rst)
    tx_pll |=> !tx_pll);

  a_r9_pll_pair: assert property (@(posedge clk) disable iff (raw_rst)
    tx_pll == rx_pll);

  a_r10_done_after_release: assert property (@(posedge clk) disable iff (raw_rst)
    $rose(seq_done) |-> $past(rel));

  a_r7_bit_clear_when_done: assert property (@(posedge clk) disable iff (raw_rst)
    seq_done |-> !sw_bit);

  a_r12_latch_only_reset: assert property (@(posedge clk) disable iff (raw_rst)
    latch_clr |-> pwr_down);
endmodule

bind xcvr_rst_seq rsq_chk #(.MAX_CYC(16)) u_chk (
  .clk       (clk),
  .raw_rst   (raw_rst),
  .hold      (hold),
  .in_rst    (in_rst),
  .rel       (rel),
  .pwr_down  (pwr_down),
  .sm_rst    (sm_rst),
  .tx_drv_en (tx_drv_en),
  .latch_clr (latch_clr),
  .tx_pll    (tx_pll_resync),
  .rx_pll    (rx_pll_resync),
  .seq_done  (seq_done),
  .sw_bit    (sw_rst_bit)
);

// File: tb/tb_xcvr_rst_seq.sv
`timescale 1ns/1ps
module tb_xcvr_rst_seq;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       por_n = 1'b0, hw_rst_n = 1'b1, sw_rst_set = 1'b0, hwsw_mode = 1'b0;
  logic [4:0] strap_addr = 5'h0B;
  logic [7:0] strap_cfg  = 8'hFF;
  logic [3:0] mac_pin_in = 4'h5, core_out = 4'hA;
  logic [3:0] core_in, mac_pin_out;
  logic       tx_drv_en, pwr_down, sm_rst, latch_clr, tx_pll_resync, rx_pll_resync;
  logic [15:0] ext_ctl;
  logic [7:0] cfg_reg;
  logic       sw_rst_bit, seq_done;

  int total = 0;
  int bad   = 0;

  xcvr_rst_seq dut (
    .clk(clk), .por_n(por_n), .hw_rst_n(hw_rst_n), .sw_rst_set(sw_rst_set),
    .hwsw_mode(hwsw_mode), .strap_addr(strap_addr), .strap_cfg(strap_cfg),
    .mac_pin_in(mac_pin_in), .core_out(core_out), .core_in(core_in),
    .mac_pin_out(mac_pin_out), .tx_drv_en(tx_drv_en), .pwr_down(pwr_down),
    .sm_rst(sm_rst), .latch_clr(latch_clr), .tx_pll_resync(tx_pll_resync),
    .rx_pll_resync(rx_pll_resync), .ext_ctl(ext_ctl), .cfg_reg(cfg_reg),
    .sw_rst_bit(sw_rst_bit), .seq_done(seq_done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  // state expected when the block is held in reset (R1)
  task automatic chk_reset_state(input string tag);
    chk({tag, " R1 pwr_down"},    32'(pwr_down),    32'd1);
    chk({tag, " R1 sm_rst"},      32'(sm_rst),      32'd1);
    chk({tag, " R1 tx_drv_en"},   32'(tx_drv_en),   32'd0);
    chk({tag, " R12 latch_clr"},  32'(latch_clr),   32'd1);
    chk({tag, " R1 core_in"},     32'(core_in),     32'd0);
    chk({tag, " R1 mac_pin_out"}, 32'(mac_pin_out), 32'd0);
    chk({tag, " R1 seq_done"},    32'(seq_done),    32'd0);
  endtask

  // Walk the exit sequence; k counts rising edges after removal of the
  // hardware sources (software entry equals k=2 at its entry edge).
  // Default STEP_GAP=1: step s is visible after edge s+2.
  task automatic seq_walk(input int off, input int kmax, input logic [4:0] ea,
                          input logic [7:0] ec, input bit swr);
    for (int k = off + 1; k <= kmax; k++) begin
      bit rel_e;
      @(posedge clk); @(negedge clk);
      rel_e = (k >= 9);
      chk($sformatf("R2/R3 pwr_down k=%0d", k), 32'(pwr_down), 32'(k < 3));
      chk($sformatf("R12 latch_clr k=%0d", k), 32'(latch_clr), 32'(k < 3));
      chk($sformatf("R3 sm_rst k=%0d", k), 32'(sm_rst), 32'(k < 5));
      chk($sformatf("R3 tx_drv_en k=%0d", k), 32'(tx_drv_en), 32'(k >= 7));
      chk($sformatf("R9 tx_pll k=%0d", k), 32'(tx_pll_resync), 32'(k == 8));
      chk($sformatf("R9 rx_pll k=%0d", k), 32'(rx_pll_resync), 32'(k == 8));
      chk($sformatf("R6 mac_pin_out k=%0d", k), 32'(mac_pin_out), rel_e ? 32'(core_out) : 32'd0);
      chk($sformatf("R11 core_in k=%0d", k), 32'(core_in), rel_e ? 32'(mac_pin_in) : 32'd0);
      chk($sformatf("R10 seq_done k=%0d", k), 32'(seq_done), 32'(k >= 10));
      if (swr) chk($sformatf("R7 sw_rst_bit k=%0d", k), 32'(sw_rst_bit), 32'(k < 10));
      if (k >= 5) chk($sformatf("R4 ext_ctl k=%0d", k), 32'(ext_ctl), 32'(ea) << 6);
      if (k >= 7) chk($sformatf("R5 cfg_reg k=%0d", k), 32'(cfg_reg), 32'(ec));
    end
  endtask

  task automatic sw_enter();
    @(negedge clk); sw_rst_set = 1'b1;
    @(posedge clk); @(negedge clk); sw_rst_set = 1'b0;
    chk_reset_state("sw entry");
    chk("R7 sw_rst_bit set", 32'(sw_rst_bit), 32'd1);
  endtask

  task automatic t_power_on();
    #1;
    chk_reset_state("por held");
    chk("R4 ext_ctl reset", 32'(ext_ctl), 32'd0);
    repeat (3) @(negedge clk);
    chk_reset_state("por held clocked");
    por_n = 1'b1;
    seq_walk(0, 12, 5'h0B, 8'h35, 1'b0);
  endtask

  task automatic t_strap_mode();
    hwsw_mode = 1'b1; strap_addr = 5'h13; strap_cfg = 8'h5C;
    sw_enter();
    seq_walk(2, 12, 5'h13, 8'h5C, 1'b1);
    @(negedge clk); strap_addr = 5'h04; strap_cfg = 8'h01; hwsw_mode = 1'b0;
    repeat (4) @(negedge clk);
    chk("R4 straps ignored in run", 32'(ext_ctl), 32'h13 << 6);
    chk("R5 cfg held in run", 32'(cfg_reg), 32'h5C);
  endtask

  task automatic t_sw_default();
    strap_addr = 5'h1F; strap_cfg = 8'hC3; hwsw_mode = 1'b0;
    sw_enter();
    seq_walk(2, 11, 5'h1F, 8'h35, 1'b1);
  endtask

  task automatic t_restart_sw();
    sw_enter();
    seq_walk(2, 7, 5'h1F, 8'h35, 1'b1);
    sw_enter();
    chk("R8 restart undoes tx", 32'(tx_drv_en), 32'd0);
    seq_walk(2, 11, 5'h1F, 8'h35, 1'b1);
  endtask

  task automatic t_restart_hw();
    sw_enter();
    seq_walk(2, 8, 5'h1F, 8'h35, 1'b1);
    #1 hw_rst_n = 1'b0;
    #1;
    chk_reset_state("R8 hw async mid-exit");
    chk("R8 sw bit cleared by pin", 32'(sw_rst_bit), 32'd0);
    @(negedge clk); @(negedge clk);
    hw_rst_n = 1'b1;
    seq_walk(0, 11, 5'h1F, 8'h35, 1'b0);
    mac_pin_in = 4'h9; core_out = 4'h6;
    #1;
    chk("R11 pass in", 32'(core_in), 32'h9);
    chk("R11 pass out", 32'(mac_pin_out), 32'h6);
  endtask

  initial begin
    #(200000 * 8);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_power_on();
    t_strap_mode();
    t_sw_default();
    t_restart_sw();
    t_restart_hw();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule